// File: doc/BRIEF.md
# Compare-Match Timer Channel Group

This block holds a small group of independent interval timers behind a simple register bus. Each channel has an up-counter that advances on ticks from its own prescaler. The prescaler divides the bus clock by 8, 32, 128 or 512, or it passes pulses from a slow-clock enable input. The counter is compared against a programmable compare value. On the tick that finds the counter equal to the compare value, the counter goes back to zero and a sticky match flag is latched. With its interrupt enable set, that flag drives the channel's interrupt request.

A single run register carries one bit per channel, so software starts and halts channels from one place. Status flags are cleared by writing them as zero. Writes to a counter do not reach the running counter at once: the new value is held and applied at the second slow-clock pulse after the write, and reads return the old value until then. The register bus has plain read and write strobes. Read data is registered and appears on the cycle after the read strobe. There is no back-pressure: every access completes in one cycle.

Register map (byte addresses): 0x00 is the run register. Channel c occupies the window 0x10*(c+1), with control/status at +0x0, the counter at +0x4 and the compare value at +0x8. Any other address reads as zero.

Top module: `cmt_timer`

## Requirements
- R1: After reset the run register, every control/status register and every counter read 0, every compare register reads all ones, and all interrupt requests are low.
- R2: Bit c of the run register (address 0x00) runs channel c, and the register reads back as written. Clearing the bit halts that counter and keeps its value. Running one channel leaves the counters of the others unchanged.
- R3: Control bits [2:0] select the tick source: 0 gives divide by 8, 1 divide by 32, 2 divide by 128, 3 divide by 512, 7 the slow-clock enable pulses, and any other code divide by 8. The divider restarts from zero while the channel is halted, so the first tick comes N bus cycles after the run bit is written.
- R4: On a tick with the counter equal to the compare value, the counter becomes 0 and the match flag (control bit 15) is set. Otherwise a tick adds one. From a run-bit write with the counter at 0, the first match is seen (compare+1)*N cycles later.
- R5: A tick with the counter at all ones and not equal to the compare value wraps the counter to 0 and sets the wrap flag (control bit 14).
- R6: Writing a control/status register with a flag bit at 0 clears that flag. Writing it at 1 leaves the flag as it was. A flag set in the same cycle as a clearing write stays set.
- R7: A channel's interrupt request equals its match flag ANDed with control bit 8. It stays high until the flag is cleared or the enable is dropped, so writing 0 to the control register removes it.
- R8: With control bit 5 at 1 the channel is periodic. With bit 5 at 0 it is one-shot: while the match flag is set, the counter holds at 0, and it resumes once the flag is cleared.
- R9: A counter write is applied at the second slow-clock pulse after the write cycle. Reads return the old value before then. A newer counter write discards the older pending value and restarts the two-pulse wait.
- R10: The compare register can be rewritten while the channel runs. It reads back as written, and the next tick compares against the new value.
- R11: Read data appears on the cycle after the read strobe. Addresses outside the map, including windows of channels that are not built, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| slow_en | input | 1 | One-cycle slow-clock pulse |
| irq | output | NCH | Interrupt request per channel |

## Verification
The bench builds the block with three channels and a 16-bit counter. The third channel makes the isolation between run bits and the address decode for a middle channel visible. The narrow counter lets a counter write near all ones reach the wrap flag after two slow-clock pulses. Exact cycle counts from the run-bit write to the interrupt are taken at divide by 8 and divide by 32. The slow-clock source then gives step-by-step control over the one-shot hold, the compare rewrite and the two-pulse counter write lag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int MATCH_BIT    = 15;
  localparam int WRAP_BIT     = 14;
  localparam int IE_BIT       = 8;
  localparam int PERIODIC_BIT = 5;
  localparam int CTRL_W       = 9;
  localparam int DIV_W        = 10;
  localparam logic [2:0] SEL_SLOW = 3'd7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // divide ratio for a prescaler code; slow-clock code handled by caller
  function automatic logic [DIV_W-1:0] pre_div(input logic [2:0] sel);
    case (sel)
      3'd1:    pre_div = DIV_W'(32);
      3'd2:    pre_div = DIV_W'(128);
      3'd3:    pre_div = DIV_W'(512);
      default: pre_div = DIV_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow_en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] lim;
  logic             use_slow;
  logic             hit;

  assign lim      = pre_div(sel) - DIV_W'(1);
  assign use_slow = (sel == SEL_SLOW);
  assign hit      = (pc_q >= lim);
  assign tick     = run && (use_slow ? slow_en : hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pc_q <= '0;
    else if (!run || use_slow)  pc_q <= '0;
    else if (hit)               pc_q <= '0;
    else                        pc_q <= pc_q + DIV_W'(1);
  end

  // R3: a divided tick is never followed by another on the next cycle
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !use_slow) |=> (!tick || use_slow));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          slow_en,
  input  logic          ctrl_we,
  input  logic          cnt_we,
  input  logic          cmp_we,
  input  logic [10:0]   ctrl_wbits,   // {flag15, flag14, ctrl[8:0]}
  input  logic [CW-1:0] val_wdata,
  output logic [15:0]   ctrl_rd,
  output logic [CW-1:0] cnt_rd,
  output logic [CW-1:0] cmp_rd,
  output logic          irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              match_q, wrap_q;
  logic [CW-1:0]     cnt_q, cmp_q, pend_q;
  logic              pend_busy, pend_seen;
  logic              tick, cnt_apply, hold, adv, at_cmp, at_max;
  logic              set_match, set_wrap;

  cmt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .slow_en (slow_en),
    .sel     (ctrl_q[2:0]),
    .tick    (tick)
  );

  assign cnt_apply = pend_busy && pend_seen && slow_en && !cnt_we;
  assign hold      = !ctrl_q[PERIODIC_BIT] && match_q;
  assign adv       = tick && !hold && !cnt_apply;
  assign at_cmp    = (cnt_q == cmp_q);
  assign at_max    = &cnt_q;
  assign set_match = adv && at_cmp;
  assign set_wrap  = adv && !at_cmp && at_max;

  // pending counter write, applied at second slow pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      pend_busy <= 1'b0;
      pend_seen <= 1'b0;
    end else if (cnt_we) begin
      pend_q    <= val_wdata;
      pend_busy <= 1'b1;
      pend_seen <= 1'b0;
    end else if (pend_busy && slow_en) begin
      if (pend_seen) begin
        pend_busy <= 1'b0;
        pend_seen <= 1'b0;
      end else begin
        pend_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_apply)  cnt_q <= pend_q;
    else if (set_match)  cnt_q <= '0;
    else if (adv)        cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_q   <= '1;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wbits[CTRL_W-1:0];
      if (cmp_we)  cmp_q  <= val_wdata;
      match_q <= (ctrl_we ? (match_q & ctrl_wbits[10]) : match_q) | set_match;
      wrap_q  <= (ctrl_we ? (wrap_q  & ctrl_wbits[9])  : wrap_q)  | set_wrap;
    end
  end

  assign ctrl_rd = {match_q, wrap_q, 5'b0, ctrl_q};
  assign cnt_rd  = cnt_q;
  assign cmp_rd  = cmp_q;
  assign irq     = match_q & ctrl_q[IE_BIT];

  // R4: a match restarts the count and raises the flag
  a_r4_match_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_cmp) |=> (cnt_q == '0 && match_q));
  // R2: a halted channel keeps its count
  a_r2_halt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_apply) |=> $stable(cnt_q));
  // R9: a counter write never lands on the cycle after it
  a_r9_no_early_apply: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !cnt_apply);
  // R6: the match flag only drops through a control write
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_q && !ctrl_we) |=> match_q);
  // R8: one-shot hold keeps the counter still
  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (match_q && !ctrl_q[PERIODIC_BIT] && !cnt_apply && !ctrl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           slow_en,
  output logic [NCH-1:0] irq
);
  localparam int BW = AW - 4;

  logic [BW-1:0]  blk;
  logic [3:0]     off;
  logic           hit_run;
  reg_sel_e       rsel;
  logic [NCH-1:0] run_q;
  logic [15:0]    ctrl_rd [NCH];
  logic [CW-1:0]  cnt_rd  [NCH];
  logic [CW-1:0]  cmp_rd  [NCH];
  logic [31:0]    rd_mux;

  assign blk     = bus_addr[AW-1:4];
  assign off     = bus_addr[3:0];
  assign hit_run = (blk == '0) && (off == 4'h0);

  always_comb begin
    case (off)
      4'h0:    rsel = REG_CTRL;
      4'h4:    rsel = REG_CNT;
      4'h8:    rsel = REG_CMP;
      default: rsel = REG_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (bus_wr && hit_run) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = (blk == BW'(c + 1));
    cmt_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q[c]),
      .slow_en    (slow_en),
      .ctrl_we    (bus_wr && sel_c && rsel == REG_CTRL),
      .cnt_we     (bus_wr && sel_c && rsel == REG_CNT),
      .cmp_we     (bus_wr && sel_c && rsel == REG_CMP),
      .ctrl_wbits ({bus_wdata[15:14], bus_wdata[8:0]}),
      .val_wdata  (bus_wdata[CW-1:0]),
      .ctrl_rd    (ctrl_rd[c]),
      .cnt_rd     (cnt_rd[c]),
      .cmp_rd     (cmp_rd[c]),
      .irq        (irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (hit_run) rd_mux = 32'(run_q);
    for (int c = 0; c < NCH; c++) begin
      if (blk == BW'(c + 1)) begin
        case (rsel)
          REG_CTRL: rd_mux = 32'(ctrl_rd[c]);
          REG_CNT:  rd_mux = 32'(cnt_rd[c]);
          REG_CMP:  rd_mux = 32'(cmp_rd[c]);
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int AW  = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, slow_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_timer #(.NCH(NCH), .CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_en(slow_en), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected item
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_val(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic pulse(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); slow_en = 1'b1;
      @(negedge clk); slow_en = 1'b0;
    end
  endtask

  task automatic wait_irq(input int b, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!irq[b] && n < 5000);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pop and compare each read result
  initial begin
    forever begin
      bit fire;
      @(posedge clk); fire = bus_rd;
      @(negedge clk);
      if (fire && q_exp.size() > 0) chk(bus_rdata, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int n;
    logic [31:0] v1, v2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(32'(irq), 0, "R1 irq after reset");
    rd(8'h00, 0, "R1 run reg");
    rd(8'h10, 0, "R1 ctrl0");
    rd(8'h24, 0, "R1 cnt1");
    rd(8'h38, 32'h0000_ffff, "R1 cmp2 all ones");
    // R11 unmapped addresses
    rd(8'h04, 0, "R11 hole in run window");
    rd(8'h40, 0, "R11 unbuilt channel");
    rd(8'h1c, 0, "R11 hole in ch0 window");

    // channel 0: divide by 8, compare 4, periodic, irq enabled
    wr(8'h18, 32'd4);
    rd(8'h18, 4, "R10 cmp readback");
    wr(8'h10, 32'h01a4);
    wr(8'h00, 32'h1);
    wait_irq(0, n);
    chk(n, 40, "R4 R3 first match at (cmp+1)*8");
    rd(8'h10, 32'h81a4, "R4 match flag set");
    rd(8'h24, 0, "R2 ch1 untouched while ch0 runs");
    wr(8'h10, 32'h81a4);
    rd(8'h10, 32'h81a4, "R6 writing one keeps flag");
    wr(8'h10, 32'h01a4);
    rd(8'h10, 32'h01a4, "R6 writing zero clears flag");
    chk(32'(irq[0]), 0, "R7 irq drops with flag");
    wait_irq(0, n);
    chk(32'(irq[0]), 1, "R7 periodic match raises irq again");
    wr(8'h10, 32'h0);
    chk(32'(irq[0]), 0, "R7 zero control write drops irq");
    rd(8'h10, 0, "R7 control reads zero");
    wr(8'h00, 32'h0);
    rd_val(8'h14, v1);
    repeat (30) @(negedge clk);
    rd_val(8'h14, v2);
    chk(v2, v1, "R2 halted counter keeps value");

    // channel 1: divide by 32, compare 0
    wr(8'h28, 32'd0);
    wr(8'h20, 32'h0121);
    wr(8'h00, 32'h2);
    wait_irq(1, n);
    chk(n, 32, "R3 divide by 32 first match");
    rd(8'h00, 32'h2, "R2 run reg readback");
    wr(8'h00, 32'h0);

    // channel 2: counter write lag with slow clock
    wr(8'h34, 32'hfffe);
    rd(8'h34, 0, "R9 old value right after write");
    pulse(1);
    rd(8'h34, 0, "R9 old value after one pulse");
    pulse(1);
    rd(8'h34, 32'hfffe, "R9 applied after two pulses");
    wr(8'h34, 32'h5);
    pulse(1);
    wr(8'h34, 32'h7);
    pulse(1);
    rd(8'h34, 32'hfffe, "R9 newer write restarts wait");
    pulse(1);
    rd(8'h34, 32'h7, "R9 newer value lands");
    wr(8'h34, 32'hfffe);
    pulse(2);

    // R5 wrap past all ones with compare 0x10, slow-clock source
    wr(8'h38, 32'h10);
    wr(8'h30, 32'h0007);
    wr(8'h00, 32'h4);
    pulse(2);
    rd(8'h30, 32'h4007, "R5 wrap flag set, match clear");
    rd(8'h34, 0, "R5 counter wrapped to zero");
    chk(32'(irq[2]), 0, "R7 no irq without enable");

    // R8 one-shot
    wr(8'h30, 32'h0107);
    pulse(17);
    rd(8'h34, 0, "R8 counter zero at match");
    chk(32'(irq[2]), 1, "R7 one-shot match irq");
    pulse(3);
    rd(8'h34, 0, "R8 one-shot holds while flag set");
    wr(8'h30, 32'h0107);
    pulse(2);
    rd(8'h34, 2, "R8 counting resumes after clear");

    // R10 compare rewrite while running
    wr(8'h38, 32'h3);
    pulse(2);
    rd(8'h34, 0, "R10 new compare matched");
    rd(8'h30, 32'h8107, "R10 match flag from new compare");

    repeat (4) @(negedge clk);
    chk(q_exp.size(), 0, "R11 every read returned data");
    done = 1'b1;
    finish_run();
  end
endmodule